// File: doc/BRIEF.md
# Instruction repeat and loop controller

This block is the repeat engine of a small DSP sequencer. A decoded repeat command carries a count operand. The block latches that count and then holds instruction fetch, so that the instruction currently offered for issue goes out count+1 times before the fetch stage moves on. The count has three possible sources, and the command code selects which one applies. The first is a 9-bit short immediate. The second is a value read from a data register. The third is a word read from data memory through a pointer. Operand fetch happens upstream, so the block receives the register or memory value directly on its operand input.

The block also holds two 8-bit loop-counter registers. Software loads these with unsigned immediates. Loading them is independent of any repeat in progress.

A repeat command that arrives while a repeat is still running is dropped, and a one-cycle error pulse reports the collision. The reset is synchronous and active-high. It clears both loop counters and ends any repeat in progress.

Top module: `rep_loop_ctrl`

## Requirements
- R1: A repeat command accepted while idle makes the instruction offered on `inst_avail` issue exactly count+1 times (one issue per cycle in which `inst_avail` is high while busy).
- R2: Command code 1 (immediate form) takes its count from `cmd_operand[8:0]` only, zero-extended; bits above bit 8 have no effect.
- R3: Command code 2 (register form) takes its count from the full 16-bit `cmd_operand`.
- R4: Command code 3 (memory form) takes its count from the full 16-bit `cmd_operand`.
- R5: A count of zero gives a single issue, and `fetch_adv` is high on that issue.
- R6: `busy` rises on the clock edge that latches the count and falls on the edge after the final issue. While busy, `fetch_adv` is high only on the final issue.
- R7: A repeat command (codes 1 to 3) received while busy is ignored, leaving the issue total of the running repeat unchanged, and `rep_err` is high for exactly the next cycle.
- R8: Command codes 4 and 5 load `cmd_operand[7:0]` into `lc0` and `lc1` respectively, on the next edge. The other counter is unaffected, and the loads work whether or not a repeat is in progress.
- R9: A synchronous reset clears `lc0`, `lc1`, `busy` and `rep_err`, and ends any active repeat.
- R10: While idle, `fetch_adv` and `issue_valid` both follow `inst_avail`.
- R11: A cycle with `inst_avail` low during a repeat consumes no iteration and keeps `fetch_adv` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | Decoded command present this cycle |
| cmd_op | input | 3 | Command code: 1 repeat-immediate, 2 repeat-register, 3 repeat-memory, 4 load lc0, 5 load lc1 |
| cmd_operand | input | 16 | Count or load value |
| inst_avail | input | 1 | Fetch stage offers an instruction for issue |
| issue_valid | output | 1 | An instruction issues this cycle |
| fetch_adv | output | 1 | Fetch may advance to the next instruction |
| busy | output | 1 | Repeat in progress |
| rep_err | output | 1 | Repeat command arrived while busy (one-cycle pulse) |
| lc0 | output | 8 | Loop counter 0 |
| lc1 | output | 8 | Loop counter 1 |

## Verification
The assertions check several behaviours on every cycle. They confirm the idle pass-through of `fetch_adv`. They confirm that `fetch_adv` during a repeat always ends the busy window. They confirm the error pulse after a colliding command, that a stalled cycle neither consumes an iteration nor advances fetch, that an accepted command raises `busy`, and the state that follows a reset. Some properties need a whole repeat to be observed, and only the bench scenarios show these. They are the exact count+1 issue total for each count source, the masking of the immediate to nine bits, the unchanged total after a collision, and the loop-counter values.

// File: rtl/rlc_pkg.sv
package rlc_pkg;
    localparam int DATA_W = 16;
    localparam int IMM_W  = 9;
    localparam int LC_W   = 8;
    localparam int NUM_LC = 2;
    localparam int OP_W   = 3;

    typedef enum logic [OP_W-1:0] {
        OP_NONE    = 3'd0,
        OP_REP_IMM = 3'd1,
        OP_REP_REG = 3'd2,
        OP_REP_MEM = 3'd3,
        OP_LD_LC0  = 3'd4,
        OP_LD_LC1  = 3'd5
    } op_e;

    typedef struct packed {
        logic              rep;
        logic [DATA_W-1:0] count;
        logic [NUM_LC-1:0] ld;
        logic [LC_W-1:0]   ld_val;
    } dec_t;

    function automatic logic is_rep_op(input logic [OP_W-1:0] op);
        return (op == OP_REP_IMM) || (op == OP_REP_REG) || (op == OP_REP_MEM);
    endfunction

    function automatic logic [DATA_W-1:0] imm_count(input logic [DATA_W-1:0] v);
        return {{(DATA_W-IMM_W){1'b0}}, v[IMM_W-1:0]};
    endfunction
endpackage

// File: rtl/rlc_decode.sv
module rlc_decode
    import rlc_pkg::*;
(
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [DATA_W-1:0] cmd_operand,
    output dec_t              dec
);
    always_comb begin
        dec.rep    = cmd_valid && is_rep_op(cmd_op);
        dec.ld_val = cmd_operand[LC_W-1:0];
        unique case (cmd_op)
            OP_REP_IMM: dec.count = imm_count(cmd_operand);
            OP_REP_REG,
            OP_REP_MEM: dec.count = cmd_operand;
            default:    dec.count = '0;
        endcase
    end

    for (genvar i = 0; i < NUM_LC; i++) begin : g_ld
        assign dec.ld[i] = cmd_valid && (cmd_op == OP_W'(int'(OP_LD_LC0) + i));
    end
endmodule

// File: rtl/rlc_repeat.sv
module rlc_repeat
    import rlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rep,
    input  logic [DATA_W-1:0] count,
    input  logic              inst_avail,
    output logic              busy,
    output logic              fetch_adv,
    output logic              rep_err
);
    logic [DATA_W-1:0] remain_q;
    logic              busy_q;
    logic              err_q;
    logic              final_it;

    assign final_it  = busy_q && (remain_q == '0);
    assign fetch_adv = inst_avail && (!busy_q || final_it);
    assign busy      = busy_q;
    assign rep_err   = err_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q   <= 1'b0;
            remain_q <= '0;
            err_q    <= 1'b0;
        end else begin
            err_q <= rep && busy_q;
            if (rep && !busy_q) begin
                busy_q   <= 1'b1;
                remain_q <= count;
            end else if (busy_q && inst_avail) begin
                if (final_it) busy_q <= 1'b0;
                else          remain_q <= remain_q - 1'b1;
            end
        end
    end
endmodule

// File: rtl/rlc_loopregs.sv
module rlc_loopregs
    import rlc_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic [NUM_LC-1:0]           ld,
    input  logic [LC_W-1:0]             ld_val,
    output logic [NUM_LC-1:0][LC_W-1:0] lc
);
    for (genvar i = 0; i < NUM_LC; i++) begin : g_lc
        always_ff @(posedge clk) begin
            if (rst)        lc[i] <= '0;
            else if (ld[i]) lc[i] <= ld_val;
        end
    end
endmodule

// File: rtl/rep_loop_ctrl.sv
module rep_loop_ctrl
    import rlc_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              cmd_valid,
    input  logic [OP_W-1:0]   cmd_op,
    input  logic [DATA_W-1:0] cmd_operand,
    input  logic              inst_avail,
    output logic              issue_valid,
    output logic              fetch_adv,
    output logic              busy,
    output logic              rep_err,
    output logic [LC_W-1:0]   lc0,
    output logic [LC_W-1:0]   lc1
);
    dec_t                        dec;
    logic [NUM_LC-1:0][LC_W-1:0] lc_q;

    rlc_decode u_dec (
        .cmd_valid   (cmd_valid),
        .cmd_op      (cmd_op),
        .cmd_operand (cmd_operand),
        .dec         (dec)
    );

    rlc_repeat u_rep (
        .clk        (clk),
        .rst        (rst),
        .rep        (dec.rep),
        .count      (dec.count),
        .inst_avail (inst_avail),
        .busy       (busy),
        .fetch_adv  (fetch_adv),
        .rep_err    (rep_err)
    );

    rlc_loopregs u_lc (
        .clk    (clk),
        .rst    (rst),
        .ld     (dec.ld),
        .ld_val (dec.ld_val),
        .lc     (lc_q)
    );

    assign issue_valid = inst_avail;
    assign lc0 = lc_q[0];
    assign lc1 = lc_q[1];
endmodule

// File: rtl/rlc_checker.sv
module rlc_checker
    import rlc_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            cmd_valid,
    input logic [OP_W-1:0] cmd_op,
    input logic            inst_avail,
    input logic            fetch_adv,
    input logic            busy,
    input logic            rep_err,
    input logic [LC_W-1:0] lc0,
    input logic [LC_W-1:0] lc1
);
    logic rep_cmd;
    assign rep_cmd = cmd_valid && is_rep_op(cmd_op);

    // R10
    p_idle_pass_r10: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (fetch_adv == inst_avail));

    // R6
    p_adv_ends_r6: assert property (@(posedge clk) disable iff (rst)
        (busy && fetch_adv && !rep_cmd) |=> !busy);

    // R6
    p_accept_busy_r6: assert property (@(posedge clk) disable iff (rst)
        (rep_cmd && !busy) |=> busy);

    // R7
    p_collide_err_r7: assert property (@(posedge clk) disable iff (rst)
        (rep_cmd && busy) |=> rep_err);

    // R7
    p_err_cause_r7: assert property (@(posedge clk) disable iff (rst)
        (!rep_cmd || !busy) |=> !rep_err);

    // R11
    p_stall_hold_r11: assert property (@(posedge clk) disable iff (rst)
        (busy && !inst_avail) |-> (!fetch_adv ##1 busy));

    // R9
    p_reset_clear_r9: assert property (@(posedge clk)
        rst |=> (!busy && !rep_err && lc0 == '0 && lc1 == '0));
endmodule

bind rep_loop_ctrl rlc_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cmd_valid  (cmd_valid),
    .cmd_op     (cmd_op),
    .inst_avail (inst_avail),
    .fetch_adv  (fetch_adv),
    .busy       (busy),
    .rep_err    (rep_err),
    .lc0        (lc0),
    .lc1        (lc1)
);

// File: tb/rep_loop_ctrl_bench.sv
`timescale 1ns/1ps
module rep_loop_ctrl_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        cmd_valid;
    logic [2:0]  cmd_op;
    logic [15:0] cmd_operand;
    logic        inst_avail;
    logic        issue_valid, fetch_adv, busy, rep_err;
    logic [7:0]  lc0, lc1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #2.5 clk = ~clk;

    rep_loop_ctrl u_rep_loop_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_operand(cmd_operand), .inst_avail(inst_avail),
        .issue_valid(issue_valid), .fetch_adv(fetch_adv), .busy(busy),
        .rep_err(rep_err), .lc0(lc0), .lc1(lc1)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic step();
        @(negedge clk);
        #1;
    endtask

    task automatic idle_inputs();
        cmd_valid = 0; cmd_op = 0; cmd_operand = 0; inst_avail = 0;
    endtask

    // Issue a repeat, then offer the instruction until busy drops.
    task automatic run_repeat(input logic [2:0] op, input logic [15:0] opnd,
                              input int exp_cnt, input bit gaps, input string req);
        int issues = 0, advs = 0, adv_at = 0, guard = 0, cyc = 0;
        bit stall_bad = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_op = op; cmd_operand = opnd; inst_avail = 0;
        @(negedge clk);
        idle_inputs();
        #1;
        chk(busy == 1, "R6 busy after latch", busy, 1);
        while (busy && guard < 70000) begin
            inst_avail = !(gaps && cyc[0]);
            #1;
            if (inst_avail && issue_valid) issues++;
            if (!inst_avail && fetch_adv) stall_bad = 1;
            if (fetch_adv) begin advs++; adv_at = issues; end
            cyc++; guard++;
            @(negedge clk);
            inst_avail = 0;
            #1;
        end
        chk(issues == exp_cnt + 1, req, issues, exp_cnt + 1);
        chk(advs == 1 && adv_at == issues, "R6 single advance on final issue", advs, 1);
        if (gaps) chk(!stall_bad, "R11 stall advanced fetch", stall_bad, 0);
    endtask

    task automatic test_reset();
        rst = 1; idle_inputs();
        step(); step();
        rst = 0;
        chk(busy == 0 && rep_err == 0, "R9 reset busy/err", busy, 0);
        chk(lc0 == 0 && lc1 == 0, "R9 reset counters", {lc0, lc1}, 0);
    endtask

    task automatic test_idle();
        @(negedge clk); inst_avail = 1; #1;
        chk(fetch_adv == 1 && issue_valid == 1, "R10 idle pass high", fetch_adv, 1);
        @(negedge clk); inst_avail = 0; #1;
        chk(fetch_adv == 0 && issue_valid == 0, "R10 idle pass low", fetch_adv, 0);
    endtask

    task automatic test_collide();
        int issues = 0, guard = 0;
        @(negedge clk);
        cmd_valid = 1; cmd_op = 3'd1; cmd_operand = 16'd4;
        @(negedge clk);
        cmd_operand = 16'd100; inst_avail = 1; #1;
        issues++;
        @(negedge clk);
        idle_inputs(); #1;
        chk(rep_err == 1, "R7 error pulse", rep_err, 1);
        inst_avail = 1; #1; issues++;
        @(negedge clk); #1;
        chk(rep_err == 0, "R7 pulse one cycle", rep_err, 0);
        while (busy && guard < 1000) begin
            issues++; guard++;
            @(negedge clk); #1;
        end
        inst_avail = 0;
        chk(issues == 5, "R7 total unchanged", issues, 5);
    endtask

    task automatic test_loopregs();
        @(negedge clk); cmd_valid = 1; cmd_op = 3'd4; cmd_operand = 16'h01A5;
        @(negedge clk); cmd_op = 3'd5; cmd_operand = 16'hFF37; #1;
        chk(lc0 == 8'hA5 && lc1 == 8'h00, "R8 load lc0", lc0, 8'hA5);
        @(negedge clk); cmd_op = 3'd1; cmd_operand = 16'd3; #1;
        chk(lc1 == 8'h37 && lc0 == 8'hA5, "R8 load lc1", lc1, 8'h37);
        @(negedge clk); cmd_op = 3'd4; cmd_operand = 16'h005C; #1;
        chk(busy == 1, "R8 repeat running", busy, 1);
        @(negedge clk); idle_inputs(); #1;
        chk(lc0 == 8'h5C && lc1 == 8'h37, "R8 load while busy", lc0, 8'h5C);
        rst = 1; step(); rst = 0;
    endtask

    task automatic test_reset_mid();
        @(negedge clk); cmd_valid = 1; cmd_op = 3'd2; cmd_operand = 16'd10;
        @(negedge clk); idle_inputs(); inst_avail = 1;
        @(negedge clk);
        rst = 1;
        @(negedge clk);
        rst = 0; #1;
        chk(busy == 0, "R9 reset ends repeat", busy, 0);
        chk(fetch_adv == 1, "R9 fetch resumes", fetch_adv, 1);
        chk(lc0 == 0 && lc1 == 0, "R9 reset clears counters", lc0, 0);
        inst_avail = 0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual 1 expected 0");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        test_reset();
        test_idle();
        run_repeat(3'd1, 16'd6,    6,   0, "R1 imm count 6");
        run_repeat(3'd1, 16'hFC03, 3,   0, "R2 imm upper bits masked");
        run_repeat(3'd1, 16'h01FF, 511, 0, "R2 imm max");
        run_repeat(3'd2, 16'd600,  600, 0, "R3 register count");
        run_repeat(3'd3, 16'd7,    7,   0, "R4 memory count");
        run_repeat(3'd1, 16'd0,    0,   0, "R5 zero count");
        run_repeat(3'd3, 16'd5,    5,   1, "R11 stalls consume nothing");
        test_collide();
        test_loopregs();
        test_reset_mid();
        test_idle();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule